// File: doc/BRIEF.md
# SDRAM Open-Page Command Sequencer

This block sits between a host that issues single-beat reads and writes and an SDRAM device. It converts each request into the minimal command series for an open-page policy. For each bank it remembers whether a row is open and which row that is. A request to the open row goes straight to a column command. A request to a bank with no open row first activates the row. A request to a bank whose open row is a different one first closes that bank with a precharge and then activates the new row. Column commands never carry auto precharge, so the row stays open after the access.

The host address is split as {bank, row, column}, with the bank in the top bits. Read data returns on a separate valid/data pair a fixed number of cycles after the read command. A separate refresh controller can take over the device through a request/grant pair. The sequencer finishes any access already in progress, then grants, and treats every bank as closed afterwards. Commands are presented combinationally from registered state, so each output cycle lines up with one SDRAM command slot.

Top module: `sdram_page_seq`

## Requirements
- R1: After reset every bank is closed, the command bus {cs_n,ras_n,cas_n,we_n} carries NOP (0111), req_ready is high, and ref_gnt, rd_valid and sd_dq_oe are low. The other encodings are ACT=0011, READ=0101, WRITE=0100 and PRE=0010.
- R2: A request to a closed bank issues ACT in the first cycle after acceptance, with the bank on sd_ba and the row on sd_a. The column command follows exactly TRCD cycles after the ACT.
- R3: A request to the row already open in its bank issues READ or WRITE in the first cycle after acceptance, with no PRE or ACT.
- R4: A request to a bank whose open row differs issues PRE to that bank with sd_a[10] low (single bank). ACT for the new row follows exactly TRP cycles later, and the column command follows TRCD cycles after the ACT.
- R5: On READ and WRITE, sd_a carries the column zero-extended, so sd_a[10] is low and there is no auto precharge. The row remains open for later hits.
- R6: A write drives sd_dq_oe high and the write data on sd_dq_out only in the WRITE cycle. sd_dqm is the inverse of the byte enables (bit i high suppresses byte i).
- R7: During a READ, sd_dqm is all zeros and sd_dq_oe is low.
- R8: For a READ issued in cycle t, the sequencer samples sd_dq_in during cycle t+CL and presents it on rd_data with rd_valid high in cycle t+CL+1 only.
- R9: While ref_gnt is high, the command bus holds NOP and req_ready is low. After the grant every bank is closed, so the next access to any bank starts with ACT.
- R10: If ref_req and req_valid are both high while idle, the refresh wins. The request is not accepted until ref_req falls.
- R11: A ref_req raised during an access in progress is granted only after that access's column command has been issued.
- R12: Banks are independent: an access to one bank leaves the open row of another bank intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BA_W+ROW_W+COL_W | {bank, row, column} |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte enables, active high |
| req_ready | output | 1 | Request accepted at this edge when req_valid is high |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DW | Read data |
| ref_req | input | 1 | Refresh controller asks for the device |
| ref_gnt | output | 1 | Device handed to the refresh controller |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_a | output | ROW_W | Multiplexed row/column address |
| sd_dqm | output | DW/8 | Byte data mask |
| sd_dq_out | output | DW | Write data to pads |
| sd_dq_oe | output | 1 | Output enable for write data |
| sd_dq_in | input | DW | Read data from pads |

## Verification
The functions that collide are host acceptance and refresh arbitration. The bench raises ref_req and req_valid at the same negative edge while the sequencer is idle. It checks that req_ready falls at once and that the grant appears at the next cycle with the bus quiet. It then checks that the held request starts afresh with an ACT, because the grant closed all banks. A second collision raises ref_req in the middle of a precharge/activate sequence. That case is judged by the column command still appearing in its computed slot, with the grant arriving only two cycles later.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_WAIT,
    ST_REFR
  } seq_state_e;

endpackage

// File: rtl/bank_row_table.sv
module bank_row_table #(
  parameter int NBANK = 4,
  parameter int BA_W  = 2,
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BA_W-1:0]  look_ba,
  input  logic [ROW_W-1:0] look_row,
  output logic             is_open,
  output logic             is_hit,
  input  logic             open_en,
  input  logic [BA_W-1:0]  open_ba,
  input  logic [ROW_W-1:0] open_row,
  input  logic             close_en,
  input  logic [BA_W-1:0]  close_ba,
  input  logic             close_all
);

  logic [NBANK-1:0] vld;
  logic [ROW_W-1:0] rows [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic             vld_q;
    logic [ROW_W-1:0] row_q;
    logic             set_me;
    logic             clr_me;

    assign set_me = open_en && (open_ba == BA_W'(g));
    assign clr_me = close_all || (close_en && (close_ba == BA_W'(g)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        row_q <= '0;
      end else begin
        if (clr_me)      vld_q <= 1'b0;
        else if (set_me) vld_q <= 1'b1;
        if (set_me)      row_q <= open_row;
      end
    end

    assign vld[g]  = vld_q;
    assign rows[g] = row_q;
  end

  assign is_open = vld[look_ba];
  assign is_hit  = is_open && (rows[look_ba] == look_row);

  // R9: a grant closes every bank in the following cycle
  assert_all_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    close_all |=> (vld == '0));

  // R2: an activate leaves that bank open
  assert_open_after_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (open_en && !close_all) |=> vld[$past(open_ba)]);

endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/rd_return_pipe.sv
module rd_return_pipe #(
  parameter int CL = 2,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [DW-1:0] dq_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  logic [CL-1:0] sh_q;
  logic          cap;

  assign cap = sh_q[CL-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      sh_q     <= {sh_q[CL-2:0], issue};
      rd_valid <= cap;
      if (cap) rd_data <= dq_in;
    end
  end

  // R8: every returned beat belongs to a read issued CL+1 cycles earlier
  assert_return_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(issue, CL + 1));

endmodule

// File: rtl/sdram_page_seq.sv
module sdram_page_seq
  import sdram_seq_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int ROW_W = 13,
  parameter int COL_W = 9,
  parameter int DW    = 32,
  parameter int TRCD  = 2,
  parameter int TRP   = 2,
  parameter int CL    = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  input  logic                               req_write,
  input  logic [$clog2(NBANK)+ROW_W+COL_W-1:0] req_addr,
  input  logic [DW-1:0]                      req_wdata,
  input  logic [DW/8-1:0]                    req_be,
  output logic                               req_ready,
  output logic                               rd_valid,
  output logic [DW-1:0]                      rd_data,
  input  logic                               ref_req,
  output logic                               ref_gnt,
  output logic                               sd_cs_n,
  output logic                               sd_ras_n,
  output logic                               sd_cas_n,
  output logic                               sd_we_n,
  output logic [$clog2(NBANK)-1:0]           sd_ba,
  output logic [ROW_W-1:0]                   sd_a,
  output logic [DW/8-1:0]                    sd_dqm,
  output logic [DW-1:0]                      sd_dq_out,
  output logic                               sd_dq_oe,
  input  logic [DW-1:0]                      sd_dq_in
);

  localparam int BA_W  = $clog2(NBANK);
  localparam int NB    = DW / 8;
  localparam int TMAX  = (TRCD > TRP) ? TRCD : TRP;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int AP_BIT = 10;

  seq_state_e st_q, st_d;
  sd_cmd_e    cmd;

  logic             rq_wr;
  logic [BA_W-1:0]  rq_ba;
  logic [ROW_W-1:0] rq_row;
  logic [COL_W-1:0] rq_col;
  logic [DW-1:0]    rq_data;
  logic [NB-1:0]    rq_be;

  logic accept;
  logic is_open, is_hit;
  logic open_en, close_en, close_all;
  logic tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  logic rd_issue;

  assign req_ready = (st_q == ST_IDLE) && !ref_req;
  assign accept    = req_ready && req_valid;
  assign ref_gnt   = (st_q == ST_REFR);

  // next-state and command decode
  always_comb begin
    st_d      = st_q;
    cmd       = CMD_NOP;
    open_en   = 1'b0;
    close_en  = 1'b0;
    close_all = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    rd_issue  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (ref_req) begin
          st_d      = ST_REFR;
          close_all = 1'b1;
        end else if (req_valid) begin
          st_d = ST_CMD;
        end
      end
      ST_CMD: begin
        if (is_hit) begin
          cmd      = rq_wr ? CMD_WR : CMD_RD;
          rd_issue = !rq_wr;
          st_d     = ST_IDLE;
        end else if (is_open) begin
          cmd      = CMD_PRE;
          close_en = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TW'(TRP - 2);
          st_d     = ST_WAIT;
        end else begin
          cmd      = CMD_ACT;
          open_en  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TW'(TRCD - 2);
          st_d     = ST_WAIT;
        end
      end
      ST_WAIT: if (tmr_done) st_d = ST_CMD;
      ST_REFR: if (!ref_req) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_wr   <= 1'b0;
      rq_ba   <= '0;
      rq_row  <= '0;
      rq_col  <= '0;
      rq_data <= '0;
      rq_be   <= '0;
    end else if (accept) begin
      rq_wr   <= req_write;
      rq_ba   <= req_addr[BA_W+ROW_W+COL_W-1 -: BA_W];
      rq_row  <= req_addr[ROW_W+COL_W-1 -: ROW_W];
      rq_col  <= req_addr[COL_W-1:0];
      rq_data <= req_wdata;
      rq_be   <= req_be;
    end
  end

  // pin drive
  always_comb begin
    {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    sd_ba     = rq_ba;
    sd_dq_out = rq_data;
    sd_dq_oe  = (cmd == CMD_WR);
    sd_dqm    = (cmd == CMD_WR) ? ~rq_be : '0;
    case (cmd)
      CMD_ACT:        sd_a = rq_row;
      CMD_RD, CMD_WR: sd_a = {{(ROW_W-COL_W){1'b0}}, rq_col};
      default:        sd_a = '0;
    endcase
  end

  bank_row_table #(.NBANK(NBANK), .BA_W(BA_W), .ROW_W(ROW_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .look_ba(rq_ba), .look_row(rq_row),
    .is_open(is_open), .is_hit(is_hit),
    .open_en(open_en), .open_ba(rq_ba), .open_row(rq_row),
    .close_en(close_en), .close_ba(rq_ba),
    .close_all(close_all)
  );

  seq_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  rd_return_pipe #(.CL(CL), .DW(DW)) u_rpipe (
    .clk(clk), .rst_n(rst_n),
    .issue(rd_issue), .dq_in(sd_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // R4: nothing follows a precharge in the very next slot
  assert_pre_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |=> (cmd == CMD_NOP));

  // R2: nothing follows an activate in the very next slot
  assert_act_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) |=> (cmd == CMD_NOP));

  // R5: column commands never request auto precharge
  assert_no_autopre_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD || cmd == CMD_WR) |-> !sd_a[AP_BIT]);

  // R7: reads leave every byte unmasked
  assert_rd_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD) |-> (sd_dqm == '0 && !sd_dq_oe));

  // R9: the bus stays quiet and closed to the host during a grant
  assert_grant_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (cmd == CMD_NOP && !req_ready));

  // R10: refresh seen while idle is granted next cycle
  assert_ref_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && st_q == ST_IDLE) |=> ref_gnt);

endmodule

// File: tb/sdram_page_seq_test.sv
module sdram_page_seq_test;

  localparam int TRCD = 3;
  localparam int TRP  = 2;
  localparam int CL   = 3;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;

  // {write, bank, row, col, data, byte enables}
  localparam int NVEC = 11;
  localparam logic [60:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 13'd5,    9'd3,   32'hA5A5_0001, 4'hF},
    {1'b0, 2'd0, 13'd5,    9'd3,   32'h0,         4'hF},
    {1'b1, 2'd0, 13'd5,    9'd10,  32'h1234_5678, 4'h5},
    {1'b1, 2'd1, 13'd9,    9'd0,   32'hDEAD_BEEF, 4'hF},
    {1'b0, 2'd0, 13'd5,    9'd3,   32'h0,         4'hF},
    {1'b0, 2'd0, 13'd7,    9'd1,   32'h0,         4'hF},
    {1'b1, 2'd0, 13'd7,    9'd511, 32'hCAFE_0007, 4'h8},
    {1'b0, 2'd2, 13'h1FFF, 9'd2,   32'h0,         4'hF},
    {1'b1, 2'd2, 13'd0,    9'd2,   32'h0BAD_F00D, 4'h0},
    {1'b0, 2'd3, 13'd1,    9'd4,   32'h0,         4'hF},
    {1'b0, 2'd1, 13'd9,    9'd5,   32'h0,         4'hF}
  };
  localparam logic [60:0] MISS_WR = {1'b1, 2'd0, 13'd33, 9'd6, 32'h5555_AAAA, 4'h3};

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_write, req_ready;
  logic [23:0] req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  req_be;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        ref_req, ref_gnt;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [12:0] sd_a;
  logic [3:0]  sd_dqm;
  logic [31:0] sd_dq_out;
  logic        sd_dq_oe;
  logic [31:0] sd_dq_in;

  int unsigned tick;
  int nchk;
  int nerr;
  logic        mo_vld [4];
  logic [12:0] mo_row [4];

  sdram_page_seq #(.TRCD(TRCD), .TRP(TRP), .CL(CL)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .ref_req(ref_req), .ref_gnt(ref_gnt),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial tick = 0;
  always @(posedge clk) tick <= tick + 1;

  function automatic logic [31:0] pat(input int unsigned t);
    return {t[15:0], ~t[15:0]};
  endfunction

  assign sd_dq_in = pat(tick);

  function automatic logic [3:0] cbus();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  // kind: 0 hit, 1 closed bank, 2 different row open
  task automatic access(input logic [60:0] v, input int ref_at);
    logic        wr;
    logic [1:0]  ba;
    logic [12:0] row;
    logic [8:0]  col;
    logic [31:0] data;
    logic [3:0]  be;
    logic [3:0]  expc;
    logic [31:0] rexp;
    string       ktag;
    int kind, kact, kacc;
    wr = v[60]; ba = v[59:58]; row = v[57:45]; col = v[44:36];
    data = v[35:4]; be = v[3:0];
    rexp = '0;
    if (mo_vld[ba] && mo_row[ba] == row) begin kind = 0; ktag = "R3"; end
    else if (mo_vld[ba])                 begin kind = 2; ktag = "R4"; end
    else                                 begin kind = 1; ktag = "R2"; end
    kact = (kind == 2) ? 1 + TRP : 1;
    kacc = (kind == 0) ? 1 : kact + TRCD;

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = {ba, row, col};
    req_wdata = data; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= kacc; k++) begin
      if (k == ref_at) ref_req = 1'b1;
      if (kind == 2 && k == 1)          expc = C_PRE;
      else if (kind != 0 && k == kact)  expc = C_ACT;
      else if (k == kacc)               expc = wr ? C_WR : C_RD;
      else                              expc = C_NOP;
      chk(cbus() == expc, (expc == C_ACT && kind == 2) ? "R4" : ktag,
          "command slot", 64'(cbus()), 64'(expc));
      if (ref_at > 0) chk(ref_gnt == 1'b0, "R11", "grant during access", 64'(ref_gnt), 0);
      if (expc == C_PRE) begin
        chk(sd_ba == ba, "R4", "precharge bank", 64'(sd_ba), 64'(ba));
        chk(sd_a[10] == 1'b0, "R4", "precharge a10", 64'(sd_a[10]), 0);
      end
      if (expc == C_ACT) begin
        chk(sd_ba == ba, ktag, "activate bank", 64'(sd_ba), 64'(ba));
        chk(sd_a == row, ktag, "activate row", 64'(sd_a), 64'(row));
      end
      if (k == kacc) begin
        chk(sd_ba == ba, "R5", "column bank", 64'(sd_ba), 64'(ba));
        chk(sd_a == {4'b0, col}, "R5", "column address", 64'(sd_a), 64'(col));
        if (wr) begin
          chk(sd_dq_oe == 1'b1, "R6", "write oe", 64'(sd_dq_oe), 1);
          chk(sd_dq_out == data, "R6", "write data", 64'(sd_dq_out), 64'(data));
          chk(sd_dqm == ~be, "R6", "write mask", 64'(sd_dqm), 64'(~be));
        end else begin
          chk(sd_dqm == 4'h0, "R7", "read mask", 64'(sd_dqm), 0);
          chk(sd_dq_oe == 1'b0, "R7", "read oe", 64'(sd_dq_oe), 0);
          rexp = pat(tick + CL);
        end
      end else begin
        chk(sd_dq_oe == 1'b0, "R6", "oe outside write", 64'(sd_dq_oe), 0);
      end
      if (k < kacc) @(negedge clk);
    end
    mo_vld[ba] = 1'b1;
    mo_row[ba] = row;
    if (!wr) begin
      repeat (CL) @(negedge clk);
      chk(rd_valid == 1'b0, "R8", "valid too early", 64'(rd_valid), 0);
      @(negedge clk);
      chk(rd_valid == 1'b1, "R8", "valid slot", 64'(rd_valid), 1);
      chk(rd_data == rexp, "R8", "read data", 64'(rd_data), 64'(rexp));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    nchk = 0; nerr = 0;
    for (int b = 0; b < 4; b++) begin mo_vld[b] = 1'b0; mo_row[b] = '0; end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; req_be = '0; ref_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(cbus() == C_NOP, "R1", "reset command", 64'(cbus()), 64'(C_NOP));
    chk(req_ready == 1'b1, "R1", "reset ready", 64'(req_ready), 1);
    chk(ref_gnt == 1'b0 && rd_valid == 1'b0 && sd_dq_oe == 1'b0, "R1", "reset flags",
        64'({ref_gnt, rd_valid, sd_dq_oe}), 0);

    // table walk: R2..R8 and R12 (bank 1 row survives bank 0 and 2 traffic)
    for (int i = 0; i < NVEC; i++) access(VEC[i], 0);

    // R10: refresh and host request in the same idle cycle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = {2'd0, 13'd5, 9'd3};
    ref_req = 1'b1;
    #1;
    chk(req_ready == 1'b0, "R10", "ready under refresh", 64'(req_ready), 0);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      chk(ref_gnt == 1'b1, "R9", "grant held", 64'(ref_gnt), 1);
      chk(cbus() == C_NOP, "R9", "quiet bus", 64'(cbus()), 64'(C_NOP));
      chk(req_ready == 1'b0, "R10", "host held off", 64'(req_ready), 0);
    end
    req_valid = 1'b0;
    ref_req = 1'b0;
    for (int b = 0; b < 4; b++) mo_vld[b] = 1'b0;
    @(negedge clk);
    chk(ref_gnt == 1'b0, "R9", "grant released", 64'(ref_gnt), 0);
    // R9: bank 0 row 5 was open; after the grant it must start with ACT
    access(VEC[1], 0);
    // R12: bank 1 closed too, so this is also an ACT
    access(VEC[10], 0);

    // R11: refresh raised mid-way through a precharge/activate sequence
    access(MISS_WR, 2);
    @(negedge clk);
    chk(ref_gnt == 1'b0, "R11", "grant one cycle after", 64'(ref_gnt), 0);
    @(negedge clk);
    chk(ref_gnt == 1'b1, "R11", "grant after access", 64'(ref_gnt), 1);
    ref_req = 1'b0;
    for (int b = 0; b < 4; b++) mo_vld[b] = 1'b0;
    @(negedge clk);
    access(MISS_WR, 0);

    summary();
  end

endmodule